// File: doc/BRIEF.md
# DMA Channel Status, Abort and Interrupt Unit

This block holds the global status side of an eight-channel DMA engine. The channel engines report three kinds of per-channel events: normal completion, completed abort, and error. The block records each event in a write-one-to-clear status bit and keeps the enable flag of every channel. It masks the status bits with per-channel interrupt masks and merges them into a single interrupt line. Register writes arrive on a plain strobe/address/data port and are decoded into three actions: a status clear, an abort request to enabled channels, and a one-cycle soft reset of the engine core.

Software enables a channel through its channel control register, which pulses `chEnableSet`. The enable flag drops in the same cycle that the channel's completion, abort or error is recorded. The vector of enable flags is offered as a read-only view.

Top module: `dma_status_unit`

## Requirements
- R1: After reset the status word, the enable vector, `irq`, `abortReq` and `coreReset` are all zero.
- R2: The status word places channel n's error flag at bit n, its abort flag at bit 8+n and its completion flag at bit 16+n. Bits 31:24 read as zero.
- R3: A `doneEvt` pulse on channel n sets its completion flag at the next clock edge, unless `abortEvt` or `errEvt` of the same channel is high in that cycle. `abortEvt` sets the abort flag and `errEvt` sets the error flag.
- R4: A write to word index 2 (status) clears every status bit whose data bit is 1. A data bit of 0 leaves the status bit unchanged.
- R5: When a hardware set and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to word index 1 (abort) raises `abortReq[n]` for exactly one cycle, the cycle after the write, for each data bit n that is 1 while channel n is enabled. Bits for disabled channels are ignored.
- R7: A write to word index 0 (control) with data bit 0 set pulses `coreReset` for one cycle and clears every enable flag at the same edge. Status bits are kept. With data bit 0 clear, the write has no effect.
- R8: `irq` is the OR over all channels of (flag AND NOT mask) across the three groups, where mask 1 disables that source. It follows mask changes without a clock edge.
- R9: `chEnableSet[n]` sets enable flag n. A recorded done, abort or error event clears it at the same edge, and the clear beats a simultaneous set.
- R10: Writes to any other word index change no state and produce no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (4) | Word index of the write |
| wrData | input | DATA_W (32) | Write data |
| chEnableSet | input | NUM_CH (8) | Per-channel enable set pulses |
| doneEvt | input | NUM_CH | Per-channel completion events |
| abortEvt | input | NUM_CH | Per-channel abort-complete events |
| errEvt | input | NUM_CH | Per-channel error events |
| maskTc | input | NUM_CH | Completion interrupt masks (1 = disabled) |
| maskAbt | input | NUM_CH | Abort interrupt masks (1 = disabled) |
| maskErr | input | NUM_CH | Error interrupt masks (1 = disabled) |
| statusWord | output | DATA_W | Status word, layout per R2 |
| chEnable | output | NUM_CH | Read-only enable flags |
| abortReq | output | NUM_CH | One-cycle abort requests to channel engines |
| coreReset | output | 1 | One-cycle soft reset pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded assertions check the following properties on every cycle:
- the write-one-to-clear action;
- set-over-clear priority;
- exclusion of the completion flag when an abort or error arrives in the same cycle;
- the drop of the enable flag after an event;
- no abort request reaching a disabled channel;
- an empty enable vector during the soft reset pulse.

The directed scenarios show the rest, because those behaviours depend on sequences of register traffic:
- the exact bit positions of the status word;
- the one-cycle width of the abort and reset pulses;
- mask-driven interrupt gating;
- the ignoring of zero-data and unmapped writes.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int GRP_W   = 8;
  localparam int ERR_LSB = 0;
  localparam int ABT_LSB = 8;
  localparam int TC_LSB  = 16;

  typedef struct packed {
    logic softReset;
    logic abortWrite;
    logic statusWrite;
  } ctrlStrobe_t;
endpackage

// File: rtl/dma_stat_ctrl.sv
module dma_stat_ctrl
  import dma_stat_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int CTRL_IDX   = 0,
  parameter int ABORT_IDX  = 1,
  parameter int STATUS_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobe_t       strobes,
  output logic              coreReset
);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_IDX);
  localparam logic [ADDR_W-1:0] ABORT_A  = ADDR_W'(ABORT_IDX);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_IDX);

  logic hitCtrl, hitAbort, hitStatus;

  always_comb begin
    hitCtrl   = wrEn && (wrAddr == CTRL_A);
    hitAbort  = wrEn && (wrAddr == ABORT_A);
    hitStatus = wrEn && (wrAddr == STATUS_A);
    strobes.softReset   = hitCtrl && wrData[0];
    strobes.abortWrite  = hitAbort;
    strobes.statusWrite = hitStatus;
  end

  // self-clearing soft reset pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coreReset <= 1'b0;
    else        coreReset <= strobes.softReset;
  end

  // R10: a write decodes to at most one register
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strobes.abortWrite, strobes.statusWrite, hitCtrl}) <= 1);
endmodule

// File: rtl/dma_stat_datapath.sv
module dma_stat_datapath
  import dma_stat_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] chEnableSet,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] abortEvt,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] maskTc,
  input  logic [NUM_CH-1:0] maskAbt,
  input  logic [NUM_CH-1:0] maskErr,
  output logic [NUM_CH-1:0] tcStat,
  output logic [NUM_CH-1:0] abtStat,
  output logic [NUM_CH-1:0] errStat,
  output logic [NUM_CH-1:0] chEnable,
  output logic [NUM_CH-1:0] abortReq,
  output logic              irq
);
  logic [NUM_CH-1:0] tcClr, abtClr, errClr, tcSet, anyEvt;

  always_comb begin
    tcClr  = strobes.statusWrite ? wrData[TC_LSB  +: NUM_CH] : '0;
    abtClr = strobes.statusWrite ? wrData[ABT_LSB +: NUM_CH] : '0;
    errClr = strobes.statusWrite ? wrData[ERR_LSB +: NUM_CH] : '0;
    tcSet  = doneEvt & ~abortEvt & ~errEvt;
    anyEvt = doneEvt | abortEvt | errEvt;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tcStat[ch]   <= 1'b0;
        abtStat[ch]  <= 1'b0;
        errStat[ch]  <= 1'b0;
        chEnable[ch] <= 1'b0;
        abortReq[ch] <= 1'b0;
      end else begin
        if (tcSet[ch])       tcStat[ch] <= 1'b1;
        else if (tcClr[ch])  tcStat[ch] <= 1'b0;
        if (abortEvt[ch])    abtStat[ch] <= 1'b1;
        else if (abtClr[ch]) abtStat[ch] <= 1'b0;
        if (errEvt[ch])      errStat[ch] <= 1'b1;
        else if (errClr[ch]) errStat[ch] <= 1'b0;

        if (strobes.softReset || anyEvt[ch]) chEnable[ch] <= 1'b0;
        else if (chEnableSet[ch])            chEnable[ch] <= 1'b1;

        abortReq[ch] <= strobes.abortWrite && wrData[ch] && chEnable[ch];
      end
    end
  end

  always_comb irq = |((tcStat & ~maskTc) | (abtStat & ~maskAbt) | (errStat & ~maskErr));

  // R4: cleared bits without a competing set read zero afterwards
  a_r4_w1c_err: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.statusWrite |=> (errStat & $past(errClr & ~errEvt)) == '0);
  // R5: a set event always leaves the bit set
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|errEvt) |=> (errStat & $past(errEvt)) == $past(errEvt));
  // R3: completion flag never newly rises alongside abort or error
  a_r3_tc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (|(doneEvt & (abortEvt | errEvt))) |=>
      (tcStat & ~$past(tcStat) & $past(abortEvt | errEvt)) == '0);
  // R9: enable drops after any recorded event
  a_r9_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (|anyEvt) |=> (chEnable & $past(anyEvt)) == '0);
  // R6: no abort request to a channel that was disabled
  a_r6_abort_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (|abortReq) |-> (abortReq & ~$past(chEnable)) == '0);
endmodule

// File: rtl/dma_status_unit.sv
module dma_status_unit
  import dma_stat_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int CTRL_IDX   = 0,
  parameter int ABORT_IDX  = 1,
  parameter int STATUS_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] chEnableSet,
  input  logic [NUM_CH-1:0] doneEvt,
  input  logic [NUM_CH-1:0] abortEvt,
  input  logic [NUM_CH-1:0] errEvt,
  input  logic [NUM_CH-1:0] maskTc,
  input  logic [NUM_CH-1:0] maskAbt,
  input  logic [NUM_CH-1:0] maskErr,
  output logic [DATA_W-1:0] statusWord,
  output logic [NUM_CH-1:0] chEnable,
  output logic [NUM_CH-1:0] abortReq,
  output logic              coreReset,
  output logic              irq
);
  localparam int PAD_W = DATA_W - TC_LSB - GRP_W;

  ctrlStrobe_t       strobes;
  logic [NUM_CH-1:0] tcStat, abtStat, errStat;
  logic [GRP_W-1:0]  tcGrp, abtGrp, errGrp;

  initial begin
    if (NUM_CH > GRP_W || NUM_CH < 1 || DATA_W < TC_LSB + GRP_W)
      $error("dma_status_unit: unsupported NUM_CH/DATA_W");
  end

  dma_stat_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_IDX(CTRL_IDX),
    .ABORT_IDX(ABORT_IDX), .STATUS_IDX(STATUS_IDX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .coreReset(coreReset)
  );

  dma_stat_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .chEnableSet(chEnableSet), .doneEvt(doneEvt), .abortEvt(abortEvt),
    .errEvt(errEvt), .maskTc(maskTc), .maskAbt(maskAbt), .maskErr(maskErr),
    .tcStat(tcStat), .abtStat(abtStat), .errStat(errStat),
    .chEnable(chEnable), .abortReq(abortReq), .irq(irq)
  );

  always_comb begin
    tcGrp  = GRP_W'(tcStat);
    abtGrp = GRP_W'(abtStat);
    errGrp = GRP_W'(errStat);
    statusWord = {{PAD_W{1'b0}}, tcGrp, abtGrp, errGrp};
  end

  // R7: during the reset pulse no channel is enabled
  a_r7_reset_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    coreReset |-> chEnable == '0);
  // R7: soft reset keeps status
  a_r7_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (coreReset && $past(doneEvt == '0 && abortEvt == '0 && errEvt == '0
                        && !strobes.statusWrite)) |-> $stable(statusWord));
endmodule

// File: tb/tb_dma_status_unit.sv
module tb_dma_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  chEnableSet = '0, doneEvt = '0, abortEvt = '0, errEvt = '0;
  logic [7:0]  maskTc = '0, maskAbt = '0, maskErr = '0;
  logic [31:0] statusWord;
  logic [7:0]  chEnable, abortReq;
  logic        coreReset, irq;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expStat = '0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_status_unit dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chEnableSet(chEnableSet), .doneEvt(doneEvt), .abortEvt(abortEvt),
    .errEvt(errEvt), .maskTc(maskTc), .maskAbt(maskAbt), .maskErr(maskErr),
    .statusWord(statusWord), .chEnable(chEnable), .abortReq(abortReq),
    .coreReset(coreReset), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge, then release all single-cycle strobes
  task automatic step();
    @(posedge clk); #1;
    wrEn = 0; chEnableSet = '0; doneEvt = '0; abortEvt = '0; errEvt = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
  endtask

  task automatic t_reset();
    chk("R1 status", statusWord, 32'h0);
    chk("R1 enable", {24'h0, chEnable}, 32'h0);
    chk("R1 abortReq", {24'h0, abortReq}, 32'h0);
    chk("R1 coreReset", {31'h0, coreReset}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_done_irq();
    chEnableSet = 8'h04; step();
    chk("R9 enable set", {24'h0, chEnable}, 32'h04);
    doneEvt = 8'h04; step();
    expStat[18] = 1'b1;
    chk("R3 R2 done ch2 at bit 18", statusWord, expStat);
    chk("R9 enable cleared on done", {24'h0, chEnable}, 32'h0);
    chk("R8 irq unmasked", {31'h0, irq}, 32'h1);
    maskTc = 8'h04; #1;
    chk("R8 irq masked", {31'h0, irq}, 32'h0);
    maskTc = 8'h00; #1;
    chk("R8 irq unmasked again", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_exclusive();
    doneEvt = 8'h20; errEvt = 8'h20; step();
    expStat[5] = 1'b1;
    chk("R3 done with error: no tc", statusWord, expStat);
    doneEvt = 8'h02; abortEvt = 8'h02; step();
    expStat[9] = 1'b1;
    chk("R3 R2 abort ch1 at bit 9, no tc", statusWord, expStat);
  endtask

  task automatic t_w1c();
    wr(4'd2, 32'h0000_0200); step();
    expStat[9] = 1'b0;
    chk("R4 clear bit 9 only", statusWord, expStat);
    wr(4'd2, 32'h0); step();
    chk("R4 zero write keeps", statusWord, expStat);
    wr(4'd2, 32'hFFFF_FFFF); step();
    expStat = '0;
    chk("R4 clear all", statusWord, expStat);
    chk("R8 irq low when clear", {31'h0, irq}, 32'h0);
    maskErr = 8'h80; errEvt = 8'h80; step();
    expStat[7] = 1'b1;
    chk("R8 masked error no irq", {31'h0, irq}, 32'h0);
    maskErr = 8'h00; #1;
    chk("R8 error irq unmasked", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_set_wins();
    errEvt = 8'h08; wr(4'd2, 32'h0000_0088); step();
    expStat[3] = 1'b1; expStat[7] = 1'b0;
    chk("R5 set beats clear", statusWord, expStat);
  endtask

  task automatic t_abort();
    chEnableSet = 8'h41; step();
    wr(4'd1, 32'h0000_00FF); step();
    chk("R6 abort only enabled", {24'h0, abortReq}, 32'h41);
    step();
    chk("R6 abort one cycle", {24'h0, abortReq}, 32'h0);
    chk("R6 abort write keeps enable", {24'h0, chEnable}, 32'h41);
  endtask

  task automatic t_soft_reset();
    chEnableSet = 8'h12; step();
    wr(4'd0, 32'hFFFF_FFFE); step();
    chk("R7 bit0 clear no reset", {31'h0, coreReset}, 32'h0);
    chk("R7 bit0 clear keeps enable", {24'h0, chEnable}, 32'h53);
    wr(4'd0, 32'h1); step();
    chk("R7 reset pulse", {31'h0, coreReset}, 32'h1);
    chk("R7 enables cleared", {24'h0, chEnable}, 32'h0);
    chk("R7 status kept", statusWord, expStat);
    step();
    chk("R7 reset self-clears", {31'h0, coreReset}, 32'h0);
  endtask

  task automatic t_bad_addr();
    chEnableSet = 8'h01; step();
    wr(4'd5, 32'hFFFF_FFFF); step();
    chk("R10 status unchanged", statusWord, expStat);
    chk("R10 no abort", {24'h0, abortReq}, 32'h0);
    chk("R10 no reset", {31'h0, coreReset}, 32'h0);
    chk("R10 enable unchanged", {24'h0, chEnable}, 32'h01);
  endtask

  task automatic t_enable_race();
    chEnableSet = 8'h08; doneEvt = 8'h08; abortEvt = 8'h01; step();
    expStat[19] = 1'b1; expStat[8] = 1'b1;
    chk("R9 event beats set", {24'h0, chEnable}, 32'h0);
    chk("R3 done ch3 and abort ch0", statusWord, expStat);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_done_irq();
    t_exclusive();
    t_w1c();
    t_set_wins();
    t_abort();
    t_soft_reset();
    t_bad_addr();
    t_enable_race();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule